// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block collects thirty-two interrupt request lines and turns them into two active-low requests for a processor: a normal request and a fast request. Every line carries its own setup: an enable bit, a detection mode, a three-bit priority and a 32-bit handler address. Line 0 always feeds the fast request. Lines 1 to 31 compete for the normal request, unless they are individually steered to the fast request. Each input first passes through a two-flop synchroniser.

Software reads the vector register to learn which handler to run. That read returns the handler address of the best pending line and records the line's priority on an in-service stack. From then on only a strictly higher priority can raise the normal request again. Writing the end-of-service register drops the top entry and restores the previous level. A protect mode moves the acknowledge action off the read and onto a separate write, so a debugger can read freely. A general mask silences both outputs while the pending state keeps tracking the inputs. A write-lock bit freezes the configuration.

The register port is synchronous. A write takes effect at the clock edge where `regWe` is high. Read data is registered and appears one cycle after `regRe`. Word addresses: 0x00+n source setup (bits [2:0] priority, [5:4] detection, bit 8 fast steer); 0x20+n handler address; 0x40 vector; 0x41 enable; 0x42 pending (read only); 0x43 acknowledge; 0x44 end of service; 0x45 control (bit 0 protect, bit 1 general mask); 0x46 spurious address; 0x47 lock (bit 0); 0x48 edge clear.

Top module: `nestIntCtrl`

## Requirements
- R1: After reset both request outputs are high, and the enable and pending registers read 0.
- R2: A line whose enable bit is 0 never drives a request output, but its pending bit is still visible at address 0x42.
- R3: Among enabled, pending, non-steered lines 1 to 31, the highest priority wins and ties go to the lowest line number. A vector read returns the winner's handler address.
- R4: Detection code in setup bits [5:4]: 0 high level, 1 rising edge, 2 low level, 3 falling edge. Lines below `EXT_FIRST` are internal and use only bit 4, so their bit 5 reads back as 0.
- R5: Acknowledging an edge-detected line clears its latched pending bit. A level line stays pending while its input is active.
- R6: While a level is in service, the normal request is driven only for a strictly higher priority. Each end-of-service write pops one level. With the stack empty, any winner drives the request.
- R7: When no winner can preempt, a vector read returns the spurious address and stacks nothing.
- R8: With control bit 0 set, a vector read has no side effect, and a write to 0x43 performs the acknowledge instead.
- R9: Line 0, and any line with setup bit 8 set, drives the fast request when enabled and pending, and takes no part in normal arbitration.
- R10: Control bit 1 holds both request outputs high while pending bits keep updating.
- R11: With lock bit 0 set, writes to setup, handler, enable, control and spurious registers are ignored.
- R12: Writing 1s to 0x48 clears the latched edge pending bits of those lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Raw interrupt request lines |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 8 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after `regRe` |
| irqN | output | 1 | Normal interrupt request, active low |
| fiqN | output | 1 | Fast interrupt request, active low |

## Verification
Two equal-priority level lines are raised together to show that the lowest number wins. A higher-priority edge pulse during service shows that preemption is strict, and a later read of the pending register confirms the latch was cleared. A second vector read at an equal level must return the spurious address. One end-of-service write must then restore the request, which shows that nothing was stacked. All four detection codes are tried on internal and external lines, with the pending register as the observation point. Protect mode, fast steering, the general mask and the write lock are each observed at the pins or through readback.

// File: rtl/nestIntPkg.sv
package nestIntPkg;
  localparam int IC_SRC    = 32;
  localparam int IC_IDX_W  = $clog2(IC_SRC);
  localparam int IC_PRIO_W = 3;
  localparam int IC_DATA_W = 32;
  localparam int IC_ADDR_W = 8;

  localparam logic [IC_ADDR_W-1:0] A_IVR    = 8'h40;
  localparam logic [IC_ADDR_W-1:0] A_ENABLE = 8'h41;
  localparam logic [IC_ADDR_W-1:0] A_PEND   = 8'h42;
  localparam logic [IC_ADDR_W-1:0] A_ACK    = 8'h43;
  localparam logic [IC_ADDR_W-1:0] A_EOC    = 8'h44;
  localparam logic [IC_ADDR_W-1:0] A_CTRL   = 8'h45;
  localparam logic [IC_ADDR_W-1:0] A_SPUR   = 8'h46;
  localparam logic [IC_ADDR_W-1:0] A_LOCK   = 8'h47;
  localparam logic [IC_ADDR_W-1:0] A_CLR    = 8'h48;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } icTrig_t;

  typedef struct packed {
    logic                cfgWe;
    logic                vecWe;
    logic                enWe;
    logic                spurWe;
    logic                clrWe;
    logic                ackClr;
    logic [IC_IDX_W-1:0] idx;
  } icStrobe_t;
endpackage

// File: rtl/nestIntCtrlDp.sv
module nestIntCtrlDp
  import nestIntPkg::*;
#(
  parameter int EXT_FIRST = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IC_SRC-1:0]     irqIn,
  input  icStrobe_t             stb,
  input  logic [IC_DATA_W-1:0]  wdata,
  input  logic [IC_ADDR_W-1:0]  rdAddr,
  output logic                  winValid,
  output logic [IC_PRIO_W-1:0]  winPrio,
  output logic [IC_IDX_W-1:0]   winId,
  output logic [IC_DATA_W-1:0]  winVector,
  output logic [IC_DATA_W-1:0]  spurVec,
  output logic                  fastReq,
  output logic [IC_DATA_W-1:0]  dpRdata
);
  logic [IC_SRC-1:0]    syncA, syncB, prevB;
  logic [IC_SRC-1:0]    pend, edgeLatch, edgeDet, fastBits, enMask, cand;
  logic [IC_PRIO_W-1:0] prioArr [IC_SRC];
  logic [1:0]           trigArr [IC_SRC];
  logic [IC_DATA_W-1:0] vecArr  [IC_SRC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= '0;
      spurVec <= '0;
    end else begin
      if (stb.enWe)   enMask  <= wdata[IC_SRC-1:0];
      if (stb.spurWe) spurVec <= wdata;
    end
  end

  for (genvar n = 0; n < IC_SRC; n++) begin : g_src
    logic [IC_PRIO_W-1:0] prioQ;
    logic [1:0]           trigQ;
    logic                 fastQ;
    logic [IC_DATA_W-1:0] vecQ;
    logic                 latchQ;
    logic                 sel, clrHit, det;

    assign sel = (stb.idx == IC_IDX_W'(n));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioQ <= '0;
        trigQ <= TRIG_HIGH;
        fastQ <= 1'b0;
        vecQ  <= '0;
      end else begin
        if (stb.cfgWe && sel) begin
          prioQ <= wdata[IC_PRIO_W-1:0];
          fastQ <= wdata[8];
          if (n >= EXT_FIRST) trigQ <= wdata[5:4];
          else                trigQ <= {1'b0, wdata[4]};
        end
        if (stb.vecWe && sel) vecQ <= wdata;
      end
    end

    assign det    = trigQ[0] & (trigQ[1] ? (prevB[n] & ~syncB[n])
                                         : (syncB[n] & ~prevB[n]));
    assign clrHit = (stb.clrWe && wdata[n]) || (stb.ackClr && sel);

    always_ff @(posedge clk) begin
      if (!rstN)          latchQ <= 1'b0;
      else if (!trigQ[0]) latchQ <= 1'b0;
      else                latchQ <= (latchQ & ~clrHit) | det;
    end

    assign pend[n]      = trigQ[0] ? latchQ : (syncB[n] ^ trigQ[1]);
    assign edgeLatch[n] = latchQ;
    assign edgeDet[n]   = det;
    assign fastBits[n]  = fastQ | (n == 0);
    assign prioArr[n]   = prioQ;
    assign trigArr[n]   = trigQ;
    assign vecArr[n]    = vecQ;
  end

  assign cand    = pend & enMask & ~fastBits;
  assign fastReq = |(pend & enMask & fastBits);

  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winId    = '0;
    for (int n = 1; n < IC_SRC; n++) begin
      if (cand[n] && (!winValid || prioArr[n] > winPrio)) begin
        winValid = 1'b1;
        winPrio  = prioArr[n];
        winId    = IC_IDX_W'(n);
      end
    end
  end

  assign winVector = vecArr[winId];

  always_comb begin
    logic [IC_IDX_W-1:0] ri;
    ri      = rdAddr[IC_IDX_W-1:0];
    dpRdata = '0;
    if (rdAddr[7:5] == 3'b000)
      dpRdata = IC_DATA_W'({fastBits[ri] & (ri != '0), 2'b00, trigArr[ri], 1'b0, prioArr[ri]});
    else if (rdAddr[7:5] == 3'b001)
      dpRdata = vecArr[ri];
    else if (rdAddr == A_ENABLE)
      dpRdata = IC_DATA_W'(enMask);
    else if (rdAddr == A_PEND)
      dpRdata = IC_DATA_W'(pend);
    else if (rdAddr == A_SPUR)
      dpRdata = spurVec;
  end

  a_r12_clear_edges: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrWe && !stb.ackClr) |=>
      ((edgeLatch & $past(wdata[IC_SRC-1:0]) & ~$past(edgeDet)) == '0));

  a_r5_ack_clears_latch: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackClr && !edgeDet[stb.idx]) |=> !edgeLatch[$past(stb.idx)]);
endmodule

// File: rtl/nestIntCtrlCtl.sv
module nestIntCtrlCtl
  import nestIntPkg::*;
#(
  parameter int STK_DEPTH = 1 << IC_PRIO_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [IC_ADDR_W-1:0]  regAddr,
  input  logic [1:0]            ctlWdata,
  input  logic                  winValid,
  input  logic [IC_PRIO_W-1:0]  winPrio,
  input  logic [IC_IDX_W-1:0]   winId,
  input  logic [IC_DATA_W-1:0]  winVector,
  input  logic [IC_DATA_W-1:0]  spurVec,
  input  logic                  fastReq,
  input  logic [IC_DATA_W-1:0]  dpRdata,
  output icStrobe_t             stb,
  output logic [IC_DATA_W-1:0]  regRdata,
  output logic                  irqN,
  output logic                  fiqN
);
  localparam int DEPTH_W = $clog2(STK_DEPTH + 1);
  localparam int SP_W    = $clog2(STK_DEPTH);

  logic                 protectMode, genMask, wlock;
  logic [IC_PRIO_W-1:0] stack [STK_DEPTH];
  logic [DEPTH_W-1:0]   depth;
  logic [IC_PRIO_W-1:0] topLevel;
  logic                 preempt, ackEvent, ackFire, eocHit, cfgRange, vecRange;

  assign topLevel = stack[SP_W'(depth - 1'b1)];
  assign preempt  = winValid && (depth == '0 || winPrio > topLevel);
  assign ackEvent = (regRe && regAddr == A_IVR && !protectMode) ||
                    (regWe && regAddr == A_ACK &&  protectMode);
  assign ackFire  = ackEvent && preempt && (depth < DEPTH_W'(STK_DEPTH));
  assign eocHit   = regWe && regAddr == A_EOC && depth != '0;
  assign cfgRange = regAddr[7:5] == 3'b000;
  assign vecRange = regAddr[7:5] == 3'b001;

  always_comb begin
    stb.ackClr = ackFire;
    stb.idx    = ackFire ? winId : regAddr[IC_IDX_W-1:0];
    stb.cfgWe  = regWe && !wlock && cfgRange && !ackFire;
    stb.vecWe  = regWe && !wlock && vecRange && !ackFire;
    stb.enWe   = regWe && !wlock && regAddr == A_ENABLE;
    stb.spurWe = regWe && !wlock && regAddr == A_SPUR;
    stb.clrWe  = regWe && regAddr == A_CLR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectMode <= 1'b0;
      genMask     <= 1'b0;
      wlock       <= 1'b0;
    end else if (regWe) begin
      if (regAddr == A_CTRL && !wlock) begin
        protectMode <= ctlWdata[0];
        genMask     <= ctlWdata[1];
      end
      if (regAddr == A_LOCK) wlock <= ctlWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stack[i] <= '0;
    end else if (ackFire) begin
      stack[SP_W'(depth)] <= winPrio;
      depth <= depth + 1'b1;
    end else if (eocHit) begin
      depth <= depth - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      irqN     <= 1'b1;
      fiqN     <= 1'b1;
    end else begin
      irqN <= !(preempt && !genMask);
      fiqN <= !(fastReq && !genMask);
      if (regRe) begin
        if (regAddr == A_IVR)       regRdata <= preempt ? winVector : spurVec;
        else if (regAddr == A_CTRL) regRdata <= IC_DATA_W'({genMask, protectMode});
        else if (regAddr == A_LOCK) regRdata <= IC_DATA_W'(wlock);
        else                        regRdata <= dpRdata;
      end
    end
  end

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(STK_DEPTH));

  a_r6_strict_push: assert property (@(posedge clk) disable iff (!rstN)
    (ackFire && depth != '0) |=> (topLevel > $past(topLevel)));

  a_r8_protect_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (protectMode && regRe && regAddr == A_IVR && !regWe) |=> (depth == $past(depth)));

  a_r10_gmask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    genMask |=> (irqN && fiqN));
endmodule

// File: rtl/nestIntCtrl.sv
module nestIntCtrl
  import nestIntPkg::*;
#(
  parameter int EXT_FIRST = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IC_SRC-1:0]    irqIn,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [IC_ADDR_W-1:0] regAddr,
  input  logic [IC_DATA_W-1:0] regWdata,
  output logic [IC_DATA_W-1:0] regRdata,
  output logic                 irqN,
  output logic                 fiqN
);
  icStrobe_t            stb;
  logic                 winValid, fastReq;
  logic [IC_PRIO_W-1:0] winPrio;
  logic [IC_IDX_W-1:0]  winId;
  logic [IC_DATA_W-1:0] winVector, spurVec, dpRdata;

  nestIntCtrlDp #(.EXT_FIRST(EXT_FIRST)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .wdata(regWdata),
    .rdAddr(regAddr), .winValid(winValid), .winPrio(winPrio), .winId(winId),
    .winVector(winVector), .spurVec(spurVec), .fastReq(fastReq), .dpRdata(dpRdata)
  );

  nestIntCtrlCtl u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .ctlWdata(regWdata[1:0]), .winValid(winValid), .winPrio(winPrio),
    .winId(winId), .winVector(winVector), .spurVec(spurVec), .fastReq(fastReq),
    .dpRdata(dpRdata), .stb(stb), .regRdata(regRdata), .irqN(irqN), .fiqN(fiqN)
  );
endmodule

// File: tb/nestIntCtrl_tb.sv
module nestIntCtrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqN, fiqN;

  int nChecks = 0, nFail = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  always #2 clk = ~clk;

  nestIntCtrl #(.EXT_FIRST(16)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqN(irqN), .fiqN(fiqN)
  );

  function automatic logic [31:0] vecOf(int n);
    return 32'h1000 + 32'(n) * 4;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); regRe = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    nChecks++;
    if (act !== e) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) rdSeen <= regRe;

  always @(negedge clk) begin
    if (rdSeen) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (regRdata !== e) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", t, regRdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    pin(irqN, 1'b1, "R1 irqN reset");
    pin(fiqN, 1'b1, "R1 fiqN reset");
    rd(8'h42, 32'h0, "R1 pending reset");
    rd(8'h41, 32'h0, "R1 enable reset");

    for (int n = 0; n < 32; n++) wr(8'h20 + 8'(n), vecOf(n));
    wr(8'h46, SPUR);
    wr(8'h02, 32'h03);
    wr(8'h03, 32'h03);
    wr(8'h05, 32'h16);

    // R2 masked line stays silent, pending visible
    irqIn[2] = 1'b1; settle();
    pin(irqN, 1'b1, "R2 masked no request");
    rd(8'h42, 32'h4, "R2 pending while masked");

    // R3 tie goes to lowest number
    irqIn[3] = 1'b1;
    wr(8'h41, 32'h2C); settle();
    pin(irqN, 1'b0, "R3 request raised");
    rd(8'h40, vecOf(2), "R3 tie lowest index");
    settle();
    pin(irqN, 1'b1, "R6 equal level no preempt");

    // R6 nesting with an edge line of higher priority
    irqIn[5] = 1'b1; repeat (2) @(negedge clk); irqIn[5] = 1'b0; settle();
    pin(irqN, 1'b0, "R6 higher priority preempts");
    rd(8'h42, 32'h2C, "R4 rising edge latched");
    rd(8'h40, vecOf(5), "R3 highest priority wins");
    settle();
    rd(8'h42, 32'h0C, "R5 edge cleared by ack, level kept");
    wr(8'h44, 32'h0); settle();
    pin(irqN, 1'b1, "R6 pop to equal level");
    wr(8'h44, 32'h0); settle();
    pin(irqN, 1'b0, "R6 empty stack request");

    // R7 spurious read stacks nothing
    rd(8'h40, vecOf(2), "R3 ack again");
    rd(8'h40, SPUR, "R7 spurious vector");
    wr(8'h44, 32'h0); settle();
    pin(irqN, 1'b0, "R7 one pop empties stack");
    irqIn[2] = 1'b0; irqIn[3] = 1'b0; settle();
    pin(irqN, 1'b1, "R6 idle after lines drop");

    // R4 detection modes
    wr(8'h10, 32'h32);
    wr(8'h11, 32'h22);
    wr(8'h04, 32'h21);
    rd(8'h04, 32'h01, "R4 internal ignores bit5");
    rd(8'h10, 32'h32, "R4 external falling code");
    settle();
    rd(8'h42, 32'h0002_0000, "R4 low level pending");
    irqIn[16] = 1'b1; irqIn[17] = 1'b1; irqIn[4] = 1'b1; settle();
    rd(8'h42, 32'h10, "R4 high level and no rise latch");
    irqIn[16] = 1'b0; irqIn[4] = 1'b0; settle();
    rd(8'h42, 32'h0001_0000, "R4 falling edge latched");
    wr(8'h48, 32'h0001_0000); settle();
    rd(8'h42, 32'h0, "R12 edge clear");

    // R8 protect mode
    wr(8'h45, 32'h1);
    irqIn[2] = 1'b1; settle();
    rd(8'h40, vecOf(2), "R8 protected read");
    settle();
    pin(irqN, 1'b0, "R8 read left no service");
    wr(8'h43, 32'h0); settle();
    pin(irqN, 1'b1, "R8 ack write services");
    wr(8'h44, 32'h0); settle();
    irqIn[5] = 1'b1; repeat (2) @(negedge clk); irqIn[5] = 1'b0; settle();
    rd(8'h40, vecOf(5), "R8 protected read edge");
    rd(8'h42, 32'h24, "R8 edge kept after read");
    wr(8'h43, 32'h0);
    rd(8'h42, 32'h04, "R8 ack write clears edge");
    wr(8'h44, 32'h0);
    wr(8'h45, 32'h0);
    irqIn[2] = 1'b0; settle();

    // R9 fast line and steering
    wr(8'h41, 32'h2D);
    irqIn[0] = 1'b1; settle();
    pin(fiqN, 1'b0, "R9 line0 fast");
    irqIn[0] = 1'b0;
    wr(8'h03, 32'h103);
    irqIn[3] = 1'b1; settle();
    pin(fiqN, 1'b0, "R9 steered fast");
    pin(irqN, 1'b1, "R9 steered not normal");
    rd(8'h40, SPUR, "R9 steered out of arbitration");
    irqIn[3] = 1'b0; settle();
    pin(fiqN, 1'b1, "R9 fast released");

    // R10 general mask
    wr(8'h45, 32'h2);
    irqIn[2] = 1'b1; settle();
    pin(irqN, 1'b1, "R10 mask holds irq");
    rd(8'h42, 32'h4, "R10 pending updates");
    wr(8'h45, 32'h0); settle();
    pin(irqN, 1'b0, "R10 unmask restores");
    irqIn[2] = 1'b0; settle();

    // R11 write lock
    wr(8'h47, 32'h1);
    wr(8'h22, 32'h55);
    rd(8'h22, vecOf(2), "R11 vector locked");
    wr(8'h41, 32'h0);
    rd(8'h41, 32'h2D, "R11 enable locked");
    irqIn[2] = 1'b1; settle();
    pin(irqN, 1'b0, "R11 locked enable active");
    wr(8'h47, 32'h0);
    wr(8'h41, 32'h0); settle();
    pin(irqN, 1'b1, "R11 unlocked write applies");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule